// File: doc/BRIEF.md
# Asynchronous Memory Strobe-Extension Sequencer

This block times one read or write access on an asynchronous external memory port. A start pulse in the idle state launches an access, which walks through a setup phase, a strobe phase and a hold phase. Each phase length comes from a per-direction configuration field, where a field value of N gives N+1 clock cycles. A single-cycle done pulse marks the last hold cycle.

With extended-wait mode enabled, the external device can stretch the strobe through a wait pin. The pin first passes through a synchroniser and a polarity setting. Its level is examined in the final programmed strobe cycle. While it is active, extra strobe cycles are inserted. When it goes inactive, the sequencer repeats the final programmed strobe cycle once and then enters hold. A programmable ceiling bounds the stretch. When the ceiling is reached, the sequencer enters hold and raises a sticky timeout bit.

The synchronised pin level is always visible. Its rising edges set a sticky flag. An interrupt output combines the enabled sticky bits.

Top module: `async_strobe_seq`

## Requirements
- R1: A start pulse in idle begins an access in the direction given by start_wr (1 = write, 0 = read). busy is high for exactly (S+1)+(T+1)+(H+1) cycles when no extension occurs, where S, T and H are that direction's setup, strobe and hold fields. strobe_act is high for T+1 of those cycles.
- R2: done is high for exactly one cycle, the last hold cycle, and busy is low in the following cycle.
- R3: A start pulse while busy is high is ignored. The running access keeps its length and produces one done.
- R4: With cfg_ext_en low the wait pin has no effect on access timing.
- R5: With extension allowed and the wait input active in the final programmed strobe cycle, extra strobe cycles are inserted. After the wait input is seen inactive, exactly one more strobe cycle follows, and then hold begins. No timeout is flagged.
- R6: An extension lasts at most cfg_max_ext+1 cycles. If the wait input is still active then, hold begins, so strobe_act lasts (T+1)+(cfg_max_ext+1) cycles, and raw_tmo is set.
- R7: With cfg_wait_pol = 1 the wait input is active when the pin is high. With cfg_wait_pol = 0 it is active when the pin is low.
- R8: Extension is allowed only when the setup field plus the strobe field of the access direction is greater than 4. Otherwise the access keeps its R1 timing.
- R9: wait_level equals the pin level delayed by the two synchroniser flops, whatever the polarity setting.
- R10: A rising edge of wait_level sets raw_rise, whatever the polarity setting. raw_rise stays set until a clr_rise pulse clears it, and a set in the same cycle wins over the clear.
- R11: raw_tmo is cleared by a clr_tmo pulse. irq is high exactly when (raw_rise and en_rise) or (raw_tmo and en_tmo).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Access request pulse, accepted in idle |
| start_wr | input | 1 | Access direction, 1 = write |
| cfg_rd_setup | input | CNT_W | Read setup field |
| cfg_rd_strobe | input | CNT_W | Read strobe field |
| cfg_rd_hold | input | CNT_W | Read hold field |
| cfg_wr_setup | input | CNT_W | Write setup field |
| cfg_wr_strobe | input | CNT_W | Write strobe field |
| cfg_wr_hold | input | CNT_W | Write hold field |
| cfg_ext_en | input | 1 | Extended-wait enable |
| cfg_wait_pol | input | 1 | Wait polarity, 1 = active high |
| cfg_max_ext | input | EXT_W | Extension ceiling field |
| wait_pin | input | 1 | Asynchronous wait pin from the device |
| clr_rise | input | 1 | Write-1 clear of raw_rise |
| clr_tmo | input | 1 | Write-1 clear of raw_tmo |
| en_rise | input | 1 | Interrupt enable for raw_rise |
| en_tmo | input | 1 | Interrupt enable for raw_tmo |
| busy | output | 1 | Access in progress |
| strobe_act | output | 1 | Strobe phase, including extension cycles |
| done | output | 1 | Last hold cycle pulse |
| wait_level | output | 1 | Synchronised raw wait level |
| raw_rise | output | 1 | Sticky wait-rise flag |
| raw_tmo | output | 1 | Sticky extension timeout flag |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions check several properties on every cycle. The strobe stays inside busy, and done is followed by idle. busy only rises after a start. No extension happens while the mode is off. The extension counter stays within the ceiling. A timeout can only come out of an extension. A release always passes through one final strobe cycle before hold. A synchronised rising edge always latches the wait-rise flag. Only the bench scenarios can show the exact cycle counts of whole accesses for each direction, field set and polarity. They also show that the setup-plus-strobe rule suppresses extension, that a mid-access start is ignored, and how the write-1 clears and interrupt masking behave.

// File: rtl/asp_pkg.sv
package asp_pkg;
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_STROBE = 3'd2,
      PH_EXTEND = 3'd3,
      PH_HOLD   = 3'd4
   } asp_phase_e;
endpackage

// File: rtl/asp_wait_sync.sv
module asp_wait_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              prev;

   if (STAGES < 2) begin : g_bad_stages
      $error("asp_wait_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= pin;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= 1'b0;
         else        chain[i] <= chain[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[STAGES-1];
   end

   assign level = chain[STAGES-1];
   assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/asp_phase_fsm.sv
module asp_phase_fsm
   import asp_pkg::*;
#(
   parameter int CNT_W   = 4,
   parameter int EXT_W   = 8,
   parameter int MIN_SUM = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_wr,
   input  logic [CNT_W-1:0] rd_setup,
   input  logic [CNT_W-1:0] rd_strobe,
   input  logic [CNT_W-1:0] rd_hold,
   input  logic [CNT_W-1:0] wr_setup,
   input  logic [CNT_W-1:0] wr_strobe,
   input  logic [CNT_W-1:0] wr_hold,
   input  logic             ext_en,
   input  logic [EXT_W-1:0] max_ext,
   input  logic             wait_act,
   output asp_phase_e       ph,
   output logic [EXT_W-1:0] ext_cnt,
   output logic             busy,
   output logic             strobe_act,
   output logic             done,
   output logic             tmo_pulse
);
   localparam int SUM_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt;
   logic             dir_wr;
   logic             resumed;
   logic [CNT_W-1:0] sel_setup, sel_strobe, sel_hold;
   logic [SUM_W-1:0] win_sum;
   logic             ext_ok;
   logic             at_ceiling;

   if (CNT_W < 3) begin : g_bad_cnt
      $error("asp_phase_fsm: CNT_W too small for the setup plus strobe rule");
   end
   if (EXT_W < 1) begin : g_bad_ext
      $error("asp_phase_fsm: EXT_W must be positive");
   end

   always_comb begin
      sel_setup  = dir_wr ? wr_setup  : rd_setup;
      sel_strobe = dir_wr ? wr_strobe : rd_strobe;
      sel_hold   = dir_wr ? wr_hold   : rd_hold;
   end

   assign win_sum    = {1'b0, sel_setup} + {1'b0, sel_strobe};
   assign ext_ok     = ext_en && (win_sum > SUM_W'(MIN_SUM));
   assign at_ceiling = (ext_cnt == max_ext);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         cnt     <= '0;
         ext_cnt <= '0;
         dir_wr  <= 1'b0;
         resumed <= 1'b0;
      end else begin
         unique case (ph)
            PH_IDLE: begin
               if (start) begin
                  dir_wr  <= start_wr;
                  cnt     <= start_wr ? wr_setup : rd_setup;
                  resumed <= 1'b0;
                  ph      <= PH_SETUP;
               end
            end
            PH_SETUP: begin
               if (cnt == '0) begin
                  cnt <= sel_strobe;
                  ph  <= PH_STROBE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_STROBE: begin
               if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end else if (ext_ok && wait_act && !resumed) begin
                  ext_cnt <= '0;
                  ph      <= PH_EXTEND;
               end else begin
                  cnt <= sel_hold;
                  ph  <= PH_HOLD;
               end
            end
            PH_EXTEND: begin
               if (!wait_act) begin
                  resumed <= 1'b1;
                  ph      <= PH_STROBE;
               end else if (at_ceiling) begin
                  cnt <= sel_hold;
                  ph  <= PH_HOLD;
               end else begin
                  ext_cnt <= ext_cnt + 1'b1;
               end
            end
            PH_HOLD: begin
               if (cnt == '0) ph <= PH_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign busy       = (ph != PH_IDLE);
   assign strobe_act = (ph == PH_STROBE) || (ph == PH_EXTEND);
   assign done       = (ph == PH_HOLD) && (cnt == '0);
   assign tmo_pulse  = (ph == PH_EXTEND) && wait_act && at_ceiling;
endmodule

// File: rtl/asp_irq_regs.sv
module asp_irq_regs (
   input  logic clk,
   input  logic rst_n,
   input  logic set_rise,
   input  logic set_tmo,
   input  logic clr_rise,
   input  logic clr_tmo,
   input  logic en_rise,
   input  logic en_tmo,
   output logic raw_rise,
   output logic raw_tmo,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_rise <= 1'b0;
         raw_tmo  <= 1'b0;
      end else begin
         if (set_rise)      raw_rise <= 1'b1;
         else if (clr_rise) raw_rise <= 1'b0;
         if (set_tmo)       raw_tmo  <= 1'b1;
         else if (clr_tmo)  raw_tmo  <= 1'b0;
      end
   end

   assign irq = (raw_rise & en_rise) | (raw_tmo & en_tmo);
endmodule

// File: rtl/async_strobe_seq.sv
module async_strobe_seq
   import asp_pkg::*;
#(
   parameter int CNT_W       = 4,
   parameter int EXT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_SUM     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_wr,
   input  logic [CNT_W-1:0] cfg_rd_setup,
   input  logic [CNT_W-1:0] cfg_rd_strobe,
   input  logic [CNT_W-1:0] cfg_rd_hold,
   input  logic [CNT_W-1:0] cfg_wr_setup,
   input  logic [CNT_W-1:0] cfg_wr_strobe,
   input  logic [CNT_W-1:0] cfg_wr_hold,
   input  logic             cfg_ext_en,
   input  logic             cfg_wait_pol,
   input  logic [EXT_W-1:0] cfg_max_ext,
   input  logic             wait_pin,
   input  logic             clr_rise,
   input  logic             clr_tmo,
   input  logic             en_rise,
   input  logic             en_tmo,
   output logic             busy,
   output logic             strobe_act,
   output logic             done,
   output logic             wait_level,
   output logic             raw_rise,
   output logic             raw_tmo,
   output logic             irq
);
   asp_phase_e       ph;
   logic [EXT_W-1:0] ext_cnt;
   logic             rise_evt;
   logic             wait_act;
   logic             tmo_pulse;

   asp_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (wait_pin),
      .level (wait_level),
      .rise  (rise_evt)
   );

   assign wait_act = cfg_wait_pol ? wait_level : ~wait_level;

   asp_phase_fsm #(.CNT_W(CNT_W), .EXT_W(EXT_W), .MIN_SUM(MIN_SUM)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_wr   (start_wr),
      .rd_setup   (cfg_rd_setup),
      .rd_strobe  (cfg_rd_strobe),
      .rd_hold    (cfg_rd_hold),
      .wr_setup   (cfg_wr_setup),
      .wr_strobe  (cfg_wr_strobe),
      .wr_hold    (cfg_wr_hold),
      .ext_en     (cfg_ext_en),
      .max_ext    (cfg_max_ext),
      .wait_act   (wait_act),
      .ph         (ph),
      .ext_cnt    (ext_cnt),
      .busy       (busy),
      .strobe_act (strobe_act),
      .done       (done),
      .tmo_pulse  (tmo_pulse)
   );

   asp_irq_regs u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_rise (rise_evt),
      .set_tmo  (tmo_pulse),
      .clr_rise (clr_rise),
      .clr_tmo  (clr_tmo),
      .en_rise  (en_rise),
      .en_tmo   (en_tmo),
      .raw_rise (raw_rise),
      .raw_tmo  (raw_tmo),
      .irq      (irq)
   );
endmodule

// File: rtl/asp_checker.sv
module asp_checker
   import asp_pkg::*;
#(
   parameter int EXT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             strobe_act,
   input logic             done,
   input logic             cfg_ext_en,
   input logic [EXT_W-1:0] cfg_max_ext,
   input logic             wait_level,
   input logic             raw_rise,
   input logic             raw_tmo,
   input asp_phase_e       ph,
   input logic [EXT_W-1:0] ext_cnt
);
   a_r1_strobe_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_act |-> busy);

   a_r2_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   a_r3_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   a_r4_no_extend_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_EXTEND) |-> cfg_ext_en);

   a_r5_release_one_final: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ph) == PH_EXTEND && ph == PH_STROBE) |=> (ph == PH_HOLD));

   a_r6_ext_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_EXTEND) |-> (ext_cnt <= cfg_max_ext));

   a_r6_tmo_from_extend: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_tmo) |-> ($past(ph) == PH_EXTEND));

   a_r10_rise_latched: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wait_level) |=> raw_rise);
endmodule

bind async_strobe_seq asp_checker #(.EXT_W(EXT_W)) u_asp_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .busy        (busy),
   .strobe_act  (strobe_act),
   .done        (done),
   .cfg_ext_en  (cfg_ext_en),
   .cfg_max_ext (cfg_max_ext),
   .wait_level  (wait_level),
   .raw_rise    (raw_rise),
   .raw_tmo     (raw_tmo),
   .ph          (ph),
   .ext_cnt     (ext_cnt)
);

// File: tb/tb_async_strobe_seq.sv
module tb_async_strobe_seq;
   localparam int CNT_W = 4;
   localparam int EXT_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, start_wr = 1'b0;
   logic [CNT_W-1:0] rd_su = '0, rd_st = '0, rd_hd = '0;
   logic [CNT_W-1:0] wr_su = '0, wr_st = '0, wr_hd = '0;
   logic ext_en = 1'b0, pol = 1'b1;
   logic [EXT_W-1:0] mx = '0;
   logic wait_pin = 1'b0;
   logic clr_rise = 1'b0, clr_tmo = 1'b0, en_rise = 1'b0, en_tmo = 1'b0;
   logic busy, strobe_act, done, wait_level, raw_rise, raw_tmo, irq;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   async_strobe_seq #(.CNT_W(CNT_W), .EXT_W(EXT_W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr),
      .cfg_rd_setup(rd_su), .cfg_rd_strobe(rd_st), .cfg_rd_hold(rd_hd),
      .cfg_wr_setup(wr_su), .cfg_wr_strobe(wr_st), .cfg_wr_hold(wr_hd),
      .cfg_ext_en(ext_en), .cfg_wait_pol(pol), .cfg_max_ext(mx),
      .wait_pin(wait_pin), .clr_rise(clr_rise), .clr_tmo(clr_tmo),
      .en_rise(en_rise), .en_tmo(en_tmo),
      .busy(busy), .strobe_act(strobe_act), .done(done),
      .wait_level(wait_level), .raw_rise(raw_rise), .raw_tmo(raw_tmo), .irq(irq)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_strobe(input int t, input bit ok, input int mode, input int m);
      if (ok && mode == 1) return t + 1 + m + 1;
      return t + 1;
   endfunction

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // mode 0: wait inactive, 1: wait held active, 2: active then released
   task automatic run_access(input bit wr, input int s, input int t, input int h,
                             input bit en, input bit p, input int m, input int mode,
                             input bit poke);
      int bc, sc, dc, guard;
      bit ok;
      start_wr = wr;
      if (wr) begin wr_su = CNT_W'(s); wr_st = CNT_W'(t); wr_hd = CNT_W'(h); end
      else    begin rd_su = CNT_W'(s); rd_st = CNT_W'(t); rd_hd = CNT_W'(h); end
      ext_en = en; pol = p; mx = EXT_W'(m);
      wait_pin = (mode == 0) ? ~p : p;
      idle(4);
      clr_tmo = 1'b1; @(negedge clk); clr_tmo = 1'b0;
      ok = en && (s + t > 4);
      start = 1'b1; @(negedge clk); start = 1'b0;
      bc = 0; sc = 0; dc = 0; guard = 0;
      while (busy && guard < 2000) begin
         bc++; guard++;
         if (strobe_act) sc++;
         if (done) dc++;
         if (mode == 2 && sc == t + 3) wait_pin = ~p;
         start = (poke && bc == 2);
         @(negedge clk);
      end
      start = 1'b0;
      if (mode == 2 && ok) begin
         check("R5", "strobe longer than programmed", int'(sc > t + 1), 1);
         check("R5", "strobe below ceiling", int'(sc <= t + 1 + m + 2), 1);
         check("R5", "no timeout on release", int'(raw_tmo), 0);
         check("R5", "busy length", bc, s + 1 + sc + h + 1);
      end else begin
         check(ok ? "R6" : (en ? "R8" : "R4"), "strobe cycles", sc, exp_strobe(t, ok, mode, m));
         check(poke ? "R3" : "R1", "busy cycles", bc, s + 1 + exp_strobe(t, ok, mode, m) + h + 1);
         check("R6", "timeout flag", int'(raw_tmo), int'(ok && mode == 1));
      end
      check("R2", "done pulses", dc, 1);
      check("R2", "idle after done", int'(busy), 0);
   endtask

   initial begin : watchdog
      while (!finished && cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5eed_1234));
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "reset busy", int'(busy), 0);
      check("R2", "reset done", int'(done), 0);
      check("R10", "reset raw_rise", int'(raw_rise), 0);
      check("R11", "reset irq", int'(irq), 0);

      // directed: basic read and write
      run_access(1'b0, 1, 2, 1, 1'b0, 1'b1, 3, 0, 1'b0);
      run_access(1'b1, 0, 0, 0, 1'b0, 1'b1, 3, 0, 1'b0);
      // R4: wait active but mode off
      run_access(1'b1, 3, 4, 2, 1'b0, 1'b1, 3, 1, 1'b0);
      // R8: sum exactly 4 blocks extension; 5 allows it
      run_access(1'b0, 2, 2, 1, 1'b1, 1'b1, 3, 1, 1'b0);
      run_access(1'b0, 2, 3, 1, 1'b1, 1'b1, 3, 1, 1'b0);
      // R7: active-low polarity, held and inactive-high
      run_access(1'b1, 3, 3, 0, 1'b1, 1'b0, 5, 1, 1'b0);
      run_access(1'b1, 3, 3, 0, 1'b1, 1'b0, 5, 0, 1'b0);
      // R6: ceiling of one cycle
      run_access(1'b0, 4, 1, 2, 1'b1, 1'b1, 0, 1, 1'b0);
      // R5: release mid-extension, both polarities
      run_access(1'b0, 2, 4, 1, 1'b1, 1'b1, 12, 2, 1'b0);
      run_access(1'b1, 5, 0, 3, 1'b1, 1'b0, 12, 2, 1'b0);
      // R3: start while busy
      run_access(1'b1, 2, 3, 2, 1'b0, 1'b1, 3, 0, 1'b1);

      // R9 and R10 with polarity low
      pol = 1'b0; wait_pin = 1'b0; idle(4);
      clr_rise = 1'b1; @(negedge clk); clr_rise = 1'b0;
      check("R10", "cleared", int'(raw_rise), 0);
      wait_pin = 1'b1;
      @(negedge clk);
      check("R9", "level after one edge", int'(wait_level), 0);
      @(negedge clk);
      check("R9", "level after two edges", int'(wait_level), 1);
      @(negedge clk);
      check("R10", "rise latched, pol 0", int'(raw_rise), 1);
      wait_pin = 1'b0; idle(4);
      check("R9", "level low", int'(wait_level), 0);
      check("R10", "sticky after fall", int'(raw_rise), 1);
      // R11 masking
      en_rise = 1'b0; #1;
      check("R11", "irq masked", int'(irq), 0);
      en_rise = 1'b1; #1;
      check("R11", "irq enabled", int'(irq), 1);
      clr_rise = 1'b1; @(negedge clk); clr_rise = 1'b0;
      check("R10", "w1c clears", int'(raw_rise), 0);
      check("R11", "irq drops", int'(irq), 0);
      en_rise = 1'b0;

      // R11 timeout interrupt and clear
      run_access(1'b0, 3, 2, 0, 1'b1, 1'b1, 2, 1, 1'b0);
      en_tmo = 1'b1; #1;
      check("R11", "irq from timeout", int'(irq), 1);
      clr_tmo = 1'b1; @(negedge clk); clr_tmo = 1'b0;
      check("R11", "timeout cleared", int'(raw_tmo), 0);
      check("R11", "irq after clear", int'(irq), 0);
      en_tmo = 1'b0;

      // constrained random accesses
      for (int k = 0; k < 60; k++) begin
         int md;
         md = int'($urandom_range(0, 2));
         run_access(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
                    int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    (md == 2) ? 12 : int'($urandom_range(0, 15)), md,
                    1'($urandom_range(0, 1)));
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule